// File: doc/BRIEF.md
# Linked-Descriptor Chain Sequencer

This block is the control half of a single DMA channel. Software places a chain of link descriptors in memory, points the current-descriptor register at the first one and sets the start bit. The sequencer reads each descriptor over a plain memory-read port. A descriptor is four words: source, destination, link to the next descriptor, and byte count. For each descriptor the sequencer hands one copy command to an external data mover and waits for the mover to finish. It then follows the link, and stops after the descriptor whose link carries the end-of-list flag in bit 0.

Software steers the channel through a small register file: a mode register, a status register, the current-descriptor address and the residual byte count. The mode register holds start, abort, external-start gating and two interrupt enables. The status register reports completion, error and activity. Its event flags are write-one-to-clear, and a single interrupt line summarises the pending events that are enabled.

Top module: `dcs_top`

## Requirements
- R1: After reset, all four registers read zero (mode at 0, status at 1, descriptor address at 2, residual at 3), and `irq`, `mv_start` and `mem_req` are low.
- R2: When the start bit (mode bit 0) goes from 0 to 1 while the channel is idle, the block reads the four words at the descriptor address plus 0, 4, 8 and 12. These are source, destination, link and count. It then raises `mv_start` for exactly one cycle, with those values on `mv_src`, `mv_dst` and `mv_len`.
- R3: The block follows each link with its low 5 bits cleared. It stops after the descriptor whose link has bit 0 set. At that point the status register reads end-of-chain (bit 0) and descriptor-done (bit 1) set and busy (bit 4) clear, and the descriptor-address register holds the address of the last descriptor.
- R4: Only the low CW bits of the count word form `mv_len`, so the largest length per descriptor is 2^CW-1.
- R5: Writing the mode register with the start bit set while it is already set starts nothing.
- R6: When mode bit 2 (external start) is set together with start, no descriptor is read and busy stays set until `ext_start` is seen high.
- R7: While the channel is busy, setting mode bit 1 (abort) returns it to idle in the next cycle. It pulses `mv_abort` if a copy is in flight, sets halted (status bit 5) and clears busy. Busy and halted are never set together.
- R8: Clearing the start bit while busy lets the running descriptor finish. Descriptor-done is then set, no further descriptor is read, halted is set, and the descriptor address is not advanced.
- R9: A copy that ends with a nonzero residual sets programming-error (status bit 2), loads the residual into register 3 and stops the chain. A zero residual never sets it.
- R10: A copy that ends with `mv_err` high sets transfer-error (status bit 3) and stops the chain.
- R11: Writing ones to status bits 0 to 3 clears them. If a hardware event sets a bit in the same cycle as the clear, the bit ends up set.
- R12: `irq` is a registered OR of end-of-chain gated by mode bit 3 and of either error flag gated by mode bit 4.
- R13: Writes to the descriptor-address register store the value with its low 5 bits cleared, and are ignored while the channel is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; data appears one cycle later |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Registered read data |
| mem_req | output | 1 | Descriptor word read request, held until acknowledged |
| mem_addr | output | AW | Byte address of the requested word |
| mem_ack | input | 1 | Read acknowledge, with data valid in the same cycle |
| mem_rdata | input | AW | Read data |
| mv_start | output | 1 | One-cycle copy command to the data mover |
| mv_src | output | AW | Copy source address |
| mv_dst | output | AW | Copy destination address |
| mv_len | output | CW | Copy length in bytes |
| mv_abort | output | 1 | One-cycle request to drop the copy in flight |
| mv_done | input | 1 | Copy finished |
| mv_resid | input | CW | Bytes left uncopied, valid with `mv_done` |
| mv_err | input | 1 | Copy failed, valid with `mv_done` |
| ext_start | input | 1 | External start gate |
| irq | output | 1 | Interrupt request |

## Verification
A software write that clears status and a hardware event that sets status can both land in the same cycle. The bench forces this by giving the data mover a fixed completion delay. Counting from the observed `mv_start`, it times a write of ones to the status register so that the write lands on exactly the negative edge where `mv_done` is driven. The following read must still show end-of-chain and descriptor-done set. A similar overlap, a command in flight when abort or stop is written, is judged by the number of copy commands logged and by the halted and done flags.

// File: rtl/dcs_pkg.sv
`timescale 1ns/1ps
package dcs_pkg;
  localparam int DESC_WORDS = 4;

  localparam logic [1:0] RA_MODE = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_CDAR = 2'd2;
  localparam logic [1:0] RA_BCNT = 2'd3;

  localparam int MB_START  = 0;
  localparam int MB_ABORT  = 1;
  localparam int MB_EXT    = 2;
  localparam int MB_IE_END = 3;
  localparam int MB_IE_ERR = 4;
  localparam int MODE_W    = 5;

  localparam int SB_END  = 0;
  localparam int SB_DESC = 1;
  localparam int SB_PERR = 2;
  localparam int SB_XERR = 3;
  localparam int FLAG_W  = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_EXT,
    ST_FETCH,
    ST_MOVE
  } dcs_state_e;
endpackage

// File: rtl/dcs_regs.sv
`timescale 1ns/1ps
module dcs_regs
  import dcs_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [1:0]        reg_addr,
  input  logic [AW-1:0]     reg_wdata,
  output logic [AW-1:0]     reg_rdata,
  input  logic              ev_end,
  input  logic              ev_desc,
  input  logic              ev_perr,
  input  logic              ev_xerr,
  input  logic              busy,
  input  logic              halted,
  input  logic [AW-1:0]     cdar,
  input  logic [CW-1:0]     bcnt,
  output logic [MODE_W-1:0] mode_bits,
  output logic              start_pulse,
  output logic              start_ext,
  output logic              cdar_we,
  output logic [AW-1:0]     cdar_wdata,
  output logic              irq
);
  logic [MODE_W-1:0] mode_q;
  logic [FLAG_W-1:0] flags_q;
  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] clr_vec;
  logic              mode_wr;
  logic              irq_q;
  logic [AW-1:0]     rdata_q;

  assign mode_wr     = reg_we && (reg_addr == RA_MODE);
  assign start_pulse = mode_wr && reg_wdata[MB_START] && !mode_q[MB_START]
                       && !reg_wdata[MB_ABORT];
  assign start_ext   = reg_wdata[MB_EXT];
  assign cdar_we     = reg_we && (reg_addr == RA_CDAR);
  assign cdar_wdata  = reg_wdata;
  assign mode_bits   = mode_q;
  assign irq         = irq_q;
  assign reg_rdata   = rdata_q;

  always_comb begin
    set_vec          = '0;
    set_vec[SB_END]  = ev_end;
    set_vec[SB_DESC] = ev_desc;
    set_vec[SB_PERR] = ev_perr;
    set_vec[SB_XERR] = ev_xerr;
    clr_vec = (reg_we && (reg_addr == RA_STAT)) ? reg_wdata[FLAG_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= reg_wdata[MODE_W-1:0];
      flags_q <= (flags_q & ~clr_vec) | set_vec;
      irq_q   <= (flags_q[SB_END] & mode_q[MB_IE_END]) |
                 ((flags_q[SB_PERR] | flags_q[SB_XERR]) & mode_q[MB_IE_ERR]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_re) begin
      case (reg_addr)
        RA_MODE: rdata_q <= {{(AW-MODE_W){1'b0}}, mode_q};
        RA_STAT: rdata_q <= {{(AW-FLAG_W-2){1'b0}}, halted, busy, flags_q};
        RA_CDAR: rdata_q <= cdar;
        default: rdata_q <= {{(AW-CW){1'b0}}, bcnt};
      endcase
    end
  end
endmodule

// File: rtl/dcs_fetch.sv
`timescale 1ns/1ps
module dcs_fetch #(
  parameter int AW = 32,
  parameter int NW = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go,
  input  logic                 flush,
  input  logic [AW-1:0]        base,
  output logic                 mem_req,
  output logic [AW-1:0]        mem_addr,
  input  logic                 mem_ack,
  input  logic [AW-1:0]        mem_rdata,
  output logic                 done,
  output logic [NW-1:0][AW-1:0] words
);
  localparam int IW = (NW > 1) ? $clog2(NW) : 1;
  localparam logic [AW-1:0] STEP = AW'(AW / 8);
  localparam logic [IW-1:0] LAST = IW'(NW - 1);

  logic          req_q;
  logic [AW-1:0] addr_q;
  logic [IW-1:0] idx_q;
  logic          done_q;
  logic [NW-1:0][AW-1:0] words_q;

  assign mem_req  = req_q;
  assign mem_addr = addr_q;
  assign done     = done_q;
  assign words    = words_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      req_q  <= 1'b0;
      addr_q <= '0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        req_q  <= 1'b1;
        addr_q <= base;
        idx_q  <= '0;
      end else if (req_q && mem_ack) begin
        if (idx_q == LAST) begin
          req_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q  <= idx_q + 1'b1;
          addr_q <= addr_q + STEP;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (req_q && mem_ack) words_q[idx_q] <= mem_rdata;
  end
endmodule

// File: rtl/dcs_ctrl.sv
`timescale 1ns/1ps
module dcs_ctrl
  import dcs_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter int ALIGN = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start_pulse,
  input  logic                          start_ext,
  input  logic                          mode_start,
  input  logic                          mode_abort,
  input  logic                          ext_start,
  input  logic                          cdar_we,
  input  logic [AW-1:0]                 cdar_wdata,
  input  logic                          fetch_done,
  input  logic [DESC_WORDS-1:0][AW-1:0] words,
  output logic                          fetch_go,
  output logic                          fetch_flush,
  output logic [AW-1:0]                 fetch_base,
  output logic                          mv_start,
  output logic [AW-1:0]                 mv_src,
  output logic [AW-1:0]                 mv_dst,
  output logic [CW-1:0]                 mv_len,
  output logic                          mv_abort,
  input  logic                          mv_done,
  input  logic [CW-1:0]                 mv_resid,
  input  logic                          mv_err,
  output logic                          busy,
  output logic                          halted,
  output logic [AW-1:0]                 cdar,
  output logic [CW-1:0]                 bcnt,
  output logic                          ev_end,
  output logic                          ev_desc,
  output logic                          ev_perr,
  output logic                          ev_xerr
);
  dcs_state_e    state_q;
  logic [AW-1:0] cdar_q, next_q, src_q, dst_q;
  logic [CW-1:0] len_q, bcnt_q;
  logic          eol_q, halted_q, mv_start_q, mv_abort_q;
  logic          abort_now, fin_ok, fin;
  logic          unused_bits;

  function automatic logic [AW-1:0] align_addr(input logic [AW-1:0] a);
    return {a[AW-1:ALIGN], {ALIGN{1'b0}}};
  endfunction

  assign unused_bits = ^{words[3][AW-1:CW], words[2][ALIGN-1:1]};

  assign abort_now   = mode_abort && (state_q != ST_IDLE);
  assign fin         = (state_q == ST_MOVE) && mv_done && !mode_abort;
  assign fin_ok      = fin && !mv_err && (mv_resid == '0);
  assign ev_desc     = fin_ok;
  assign ev_end      = fin_ok && eol_q;
  assign ev_perr     = fin && !mv_err && (mv_resid != '0);
  assign ev_xerr     = fin && mv_err;
  assign fetch_flush = abort_now;
  assign fetch_base  = (state_q == ST_MOVE) ? next_q : cdar_q;
  assign fetch_go    = ((state_q == ST_IDLE) && start_pulse && !start_ext) ||
                       ((state_q == ST_WAIT_EXT) && ext_start && mode_start && !mode_abort) ||
                       (fin_ok && !eol_q && mode_start);

  assign busy     = (state_q != ST_IDLE);
  assign halted   = halted_q;
  assign cdar     = cdar_q;
  assign bcnt     = bcnt_q;
  assign mv_start = mv_start_q;
  assign mv_abort = mv_abort_q;
  assign mv_src   = src_q;
  assign mv_dst   = dst_q;
  assign mv_len   = len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cdar_q     <= '0;
      next_q     <= '0;
      src_q      <= '0;
      dst_q      <= '0;
      len_q      <= '0;
      bcnt_q     <= '0;
      eol_q      <= 1'b0;
      halted_q   <= 1'b0;
      mv_start_q <= 1'b0;
      mv_abort_q <= 1'b0;
    end else begin
      mv_start_q <= 1'b0;
      mv_abort_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (cdar_we) cdar_q <= align_addr(cdar_wdata);
          if (start_pulse) begin
            halted_q <= 1'b0;
            state_q  <= start_ext ? ST_WAIT_EXT : ST_FETCH;
          end
        end
        ST_WAIT_EXT: begin
          if (mode_abort || !mode_start) begin
            halted_q <= 1'b1;
            state_q  <= ST_IDLE;
          end else if (ext_start) begin
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mode_abort) begin
            halted_q <= 1'b1;
            state_q  <= ST_IDLE;
          end else if (fetch_done) begin
            src_q      <= words[0];
            dst_q      <= words[1];
            next_q     <= align_addr(words[2]);
            eol_q      <= words[2][0];
            len_q      <= words[3][CW-1:0];
            mv_start_q <= 1'b1;
            state_q    <= ST_MOVE;
          end
        end
        default: begin
          if (mode_abort) begin
            mv_abort_q <= 1'b1;
            halted_q   <= 1'b1;
            state_q    <= ST_IDLE;
          end else if (mv_done) begin
            bcnt_q <= mv_resid;
            if (!fin_ok || eol_q) begin
              state_q <= ST_IDLE;
            end else if (!mode_start) begin
              halted_q <= 1'b1;
              state_q  <= ST_IDLE;
            end else begin
              cdar_q  <= next_q;
              state_q <= ST_FETCH;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dcs_top.sv
`timescale 1ns/1ps
module dcs_top
  import dcs_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter int ALIGN = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [1:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata,
  output logic          mv_start,
  output logic [AW-1:0] mv_src,
  output logic [AW-1:0] mv_dst,
  output logic [CW-1:0] mv_len,
  output logic          mv_abort,
  input  logic          mv_done,
  input  logic [CW-1:0] mv_resid,
  input  logic          mv_err,
  input  logic          ext_start,
  output logic          irq
);
  logic [MODE_W-1:0]              mode_bits;
  logic                           start_pulse, start_ext, cdar_we;
  logic [AW-1:0]                  cdar_wdata, cdar, fetch_base;
  logic [CW-1:0]                  bcnt;
  logic                           busy, halted;
  logic                           ev_end, ev_desc, ev_perr, ev_xerr;
  logic                           fetch_go, fetch_flush, fetch_done;
  logic [DESC_WORDS-1:0][AW-1:0]  words;

  dcs_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_end(ev_end), .ev_desc(ev_desc), .ev_perr(ev_perr), .ev_xerr(ev_xerr),
    .busy(busy), .halted(halted), .cdar(cdar), .bcnt(bcnt),
    .mode_bits(mode_bits), .start_pulse(start_pulse), .start_ext(start_ext),
    .cdar_we(cdar_we), .cdar_wdata(cdar_wdata), .irq(irq)
  );

  dcs_fetch #(.AW(AW), .NW(DESC_WORDS)) u_fetch (
    .clk(clk), .rst(rst), .go(fetch_go), .flush(fetch_flush), .base(fetch_base),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .done(fetch_done), .words(words)
  );

  dcs_ctrl #(.AW(AW), .CW(CW), .ALIGN(ALIGN)) u_ctrl (
    .clk(clk), .rst(rst),
    .start_pulse(start_pulse), .start_ext(start_ext),
    .mode_start(mode_bits[MB_START]), .mode_abort(mode_bits[MB_ABORT]),
    .ext_start(ext_start), .cdar_we(cdar_we), .cdar_wdata(cdar_wdata),
    .fetch_done(fetch_done), .words(words),
    .fetch_go(fetch_go), .fetch_flush(fetch_flush), .fetch_base(fetch_base),
    .mv_start(mv_start), .mv_src(mv_src), .mv_dst(mv_dst), .mv_len(mv_len),
    .mv_abort(mv_abort), .mv_done(mv_done), .mv_resid(mv_resid), .mv_err(mv_err),
    .busy(busy), .halted(halted), .cdar(cdar), .bcnt(bcnt),
    .ev_end(ev_end), .ev_desc(ev_desc), .ev_perr(ev_perr), .ev_xerr(ev_xerr)
  );
endmodule

// File: rtl/dcs_checker.sv
`timescale 1ns/1ps
module dcs_checker
  import dcs_pkg::*;
#(
  parameter int AW = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mv_start,
  input logic              mv_abort,
  input logic              busy,
  input logic              halted,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [AW-1:0]     mem_addr,
  input logic [MODE_W-1:0] mode_bits,
  input logic              irq
);
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mv_start |=> !mv_start); // R2
  AST_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    mv_start |-> busy); // R2
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack && !mode_bits[MB_ABORT]) |=> (mem_req && $stable(mem_addr))); // R2
  AST_HALT_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    halted |-> !busy); // R7
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_bits[MB_ABORT]) |=> !busy); // R7
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (rst)
    mv_abort |-> (!busy && halted)); // R7
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(mode_bits[MB_IE_END] || mode_bits[MB_IE_ERR])); // R12
endmodule

bind dcs_top dcs_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mv_start(mv_start), .mv_abort(mv_abort),
  .busy(busy), .halted(halted), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mode_bits(mode_bits), .irq(irq)
);

// File: tb/sim_dcs_top.sv
`timescale 1ns/1ps
module sim_dcs_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_ack;
  logic [31:0] mem_addr, mem_rdata;
  logic        mv_start, mv_abort;
  logic [31:0] mv_src, mv_dst;
  logic [15:0] mv_len;
  logic        mv_done = 1'b0;
  logic [15:0] mv_resid = '0;
  logic        mv_err = 1'b0;
  logic        ext_start = 1'b0;
  logic        irq;

  always #4 clk = ~clk;

  dcs_top u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mv_start(mv_start), .mv_src(mv_src), .mv_dst(mv_dst), .mv_len(mv_len),
    .mv_abort(mv_abort), .mv_done(mv_done), .mv_resid(mv_resid), .mv_err(mv_err),
    .ext_start(ext_start), .irq(irq)
  );

  logic [31:0] mem [0:63];
  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[7:2]];

  int checks = 0, fails = 0;
  bit finished = 0;

  int          log_n = 0;
  logic [31:0] log_src [0:7];
  logic [31:0] log_dst [0:7];
  logic [15:0] log_len [0:7];
  int          mv_cnt = 0;
  int          extra_dly = 0;
  logic [15:0] knob_resid = '0;
  logic        knob_err = 1'b0;
  int          abort_pulses = 0;

  logic [31:0] exp_src [0:7];
  logic [31:0] exp_dst [0:7];
  logic [15:0] exp_len [0:7];
  logic [31:0] first_addr, last_addr;

  always @(negedge clk) begin
    mv_done = 1'b0;
    if (mv_abort) begin
      abort_pulses++;
      mv_cnt = 0;
    end else if (mv_cnt == 1) begin
      mv_done  = 1'b1;
      mv_resid = knob_resid;
      mv_err   = knob_err;
      mv_cnt   = 0;
    end else if (mv_cnt > 1) begin
      mv_cnt--;
    end
    if (mv_start) begin
      if (log_n < 8) begin
        log_src[log_n] = mv_src;
        log_dst[log_n] = mv_dst;
        log_len[log_n] = mv_len;
      end
      mv_cnt = 1 + (log_n % 3) + extra_dly;
      log_n++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 2000; k++) begin
      rd(2'd1, v);
      if (!v[4]) break;
    end
  endtask

  function automatic logic [31:0] slot_addr(input int s);
    return 32'(s * 32);
  endfunction

  task automatic make_chain(input int n);
    for (int i = 0; i < n; i++) begin
      int s, sn;
      logic [31:0] cw, lk;
      s  = (i * 3 + n) % 8;
      sn = ((i + 1) * 3 + n) % 8;
      exp_src[i] = 32'h1000_0000 + 32'(n * 256 + i * 16);
      exp_dst[i] = 32'h2000_0000 + 32'(n * 512 + i * 32);
      cw = (n == 4 && i == 3) ? 32'h0001_FFFF : (32'h5A00_0000 | 32'((i + 1) * (n + 7)));
      exp_len[i] = cw[15:0];
      lk = (i == n - 1) ? (32'h0000_0040 | 32'h1) : (slot_addr(sn) | 32'h16);
      mem[s * 8 + 0] = exp_src[i];
      mem[s * 8 + 1] = exp_dst[i];
      mem[s * 8 + 2] = lk;
      mem[s * 8 + 3] = cw;
      if (i == 0) first_addr = slot_addr(s);
      if (i == n - 1) last_addr = slot_addr(s);
    end
  endtask

  task automatic prep();
    wr(2'd0, 32'h0);
    wr(2'd1, 32'hF);
    knob_resid = '0; knob_err = 1'b0; extra_dly = 0;
    log_n = 0; abort_pulses = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int k = 0; k < 64; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 mv_start", {31'b0, mv_start}, 32'h0);
    check("R1 mem_req", {31'b0, mem_req}, 32'h0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 register", v, 32'h0);
    end

    // R2 R3 R4 sweep over chain lengths
    for (int n = 1; n <= 4; n++) begin
      prep();
      make_chain(n);
      wr(2'd2, first_addr | 32'h13);
      rd(2'd2, v);
      check("R13 aligned cdar", v, first_addr);
      wr(2'd0, 32'h9);
      wait_idle();
      check("R2 command count", 32'(log_n), 32'(n));
      for (int i = 0; i < n; i++) begin
        check("R2 src", log_src[i], exp_src[i]);
        check("R2 dst", log_dst[i], exp_dst[i]);
        check("R4 len", {16'b0, log_len[i]}, {16'b0, exp_len[i]});
      end
      rd(2'd1, v);
      check("R3 status end", v, 32'h3);
      rd(2'd2, v);
      check("R3 cdar last", v, last_addr);
      rd(2'd3, v);
      check("R9 zero residual", v, 32'h0);
      check("R12 irq end", {31'b0, irq}, 32'h1);
      wr(2'd1, 32'hF);
      rd(2'd1, v);
      check("R11 w1c", v, 32'h0);
      check("R12 irq cleared", {31'b0, irq}, 32'h0);
    end

    // R6 external start, then R5 restart without a 0->1 edge
    prep();
    make_chain(1);
    wr(2'd2, first_addr);
    wr(2'd0, 32'h5);
    repeat (12) @(negedge clk);
    check("R6 no fetch before pin", 32'(log_n), 32'h0);
    rd(2'd1, v);
    check("R6 busy while waiting", v, 32'h10);
    @(negedge clk) ext_start = 1'b1;
    @(negedge clk) ext_start = 1'b0;
    wait_idle();
    check("R6 ran after pin", 32'(log_n), 32'h1);
    wr(2'd0, 32'h1);
    repeat (20) @(negedge clk);
    check("R5 no restart", 32'(log_n), 32'h1);
    rd(2'd1, v);
    check("R5 still idle", v, 32'h3);

    // R7 abort mid copy, R13 cdar ignored while busy
    prep();
    make_chain(2);
    wr(2'd2, first_addr);
    extra_dly = 20;
    wr(2'd0, 32'h1);
    do @(negedge clk); while (!mv_start);
    wr(2'd2, 32'h0000_00E0);
    rd(2'd2, v);
    check("R13 busy write ignored", v, first_addr);
    wr(2'd0, 32'h3);
    rd(2'd1, v);
    check("R7 halted not busy", v, 32'h20);
    check("R7 abort pulse", 32'(abort_pulses), 32'h1);
    repeat (40) @(negedge clk);
    check("R7 no further command", 32'(log_n), 32'h1);
    rd(2'd1, v);
    check("R7 no done flag", v, 32'h20);

    // R8 stop by clearing start
    prep();
    make_chain(2);
    wr(2'd2, first_addr);
    extra_dly = 5;
    wr(2'd0, 32'h1);
    do @(negedge clk); while (!mv_start);
    wr(2'd0, 32'h0);
    wait_idle();
    rd(2'd1, v);
    check("R8 done and halted", v, 32'h22);
    check("R8 one command", 32'(log_n), 32'h1);
    rd(2'd2, v);
    check("R8 cdar kept", v, first_addr);

    // R9 nonzero residual
    prep();
    make_chain(2);
    wr(2'd2, first_addr);
    knob_resid = 16'h0040;
    wr(2'd0, 32'h11);
    wait_idle();
    rd(2'd1, v);
    check("R9 prog error", v, 32'h4);
    rd(2'd3, v);
    check("R9 residual", v, 32'h40);
    check("R9 stopped", 32'(log_n), 32'h1);
    check("R12 irq error", {31'b0, irq}, 32'h1);

    // R10 transfer error
    prep();
    make_chain(2);
    wr(2'd2, first_addr);
    knob_err = 1'b1;
    wr(2'd0, 32'h11);
    wait_idle();
    rd(2'd1, v);
    check("R10 xfer error", v, 32'h8);
    check("R10 stopped", 32'(log_n), 32'h1);
    check("R12 irq xerr", {31'b0, irq}, 32'h1);

    // R12 enable gating: end event with enables off
    prep();
    make_chain(1);
    wr(2'd2, first_addr);
    wr(2'd0, 32'h1);
    wait_idle();
    repeat (2) @(negedge clk);
    check("R12 irq masked", {31'b0, irq}, 32'h0);

    // R11 clear and set in the same cycle
    prep();
    make_chain(1);
    wr(2'd2, first_addr);
    extra_dly = 3;
    wr(2'd0, 32'h1);
    do @(negedge clk); while (!mv_start);
    repeat (3) @(negedge clk);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 32'hF;
    @(negedge clk);
    reg_we = 1'b0;
    rd(2'd1, v);
    check("R11 set wins", v, 32'h3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule